// File: doc/BRIEF.md
# First-Error Capture and Interrupt Unit

This block gathers error indications raised by a processor bus interface and turns them into a maskable level interrupt. Each of eight error kinds has a sticky cause bit that software clears by writing zero to it. Next to the cause bits, the block holds a freeze-frame of the first error it saw: the faulting address, the four address parity bits, and, for data parity errors, the 64-bit data word and its eight parity bits. A selector field reports which error kind the freeze-frame belongs to.

After a capture, the freeze-frame is locked. Later errors still set their cause bits, but they do not overwrite the captured details. Software re-arms capture by reading the captured low address word, which an interrupt handler reads last. The checks that detect the errors sit outside this block. They present one strobe per error kind, together with the address, data and parity of the transaction involved.

Top module: `err_capture_unit`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and capture is armed.
- R2: A strobe on `evt_valid[k]` sets cause bit k at the next clock edge. The bits map as follows: 0 address out of range, 1 address parity, 2 burst to an internal register, 3 access-protected region, 4 write-protected region, 5 caching-protected region, 6 write data parity, 7 read data parity.
- R3: A write to the cause register (index 0) clears every cause bit whose `reg_wdata` bit is 0 and leaves the bits written with 1 unchanged. An event in the same cycle as a clearing write leaves its bit set.
- R4: `irq` is high exactly when some cause bit is set and its mask bit is also set. The mask register is index 1, bits 7:0, and can be read back.
- R5: When armed, any event captures. Cause bits 31:27 then hold the index of the lowest-numbered event present in that cycle (a value from 0 to 7). The captured address reads at index 2, and the address parity reads at index 3, bits 7:4.
- R6: If the selected event is 6 or 7, the captured data reads as its low word at index 4 and its high word at index 5, with the data parity at index 6, bits 7:0. For any other selected event, these three registers read zero.
- R7: After a capture, further events set cause bits but change neither the captured fields nor the selector. Only a read of index 2 re-arms capture.
- R8: An event in the same cycle as a read of index 2 is captured. The read itself returns the old address.
- R9: Reserved bits and index 7 read zero. Writes to reserved bits, to the selector field and to indices 2 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of index 2 re-arms capture) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_idx` |
| evt_valid | input | 8 | One strobe per error kind |
| evt_addr | input | 32 | Address of the erring transaction |
| evt_apar | input | 4 | Address parity bits |
| evt_data | input | 64 | Data of the erring transaction |
| evt_dpar | input | 8 | Data parity bits |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after these cases:
- A second error while the unit is locked. A unit that fails to lock would report the later address and selector.
- Two errors in one cycle. Wrong priority shows up as selector 6 in place of 2, with data wrongly captured.
- An error that coincides with the unlocking read. A design that applies the lock first would lose that error entirely.
- A clearing write that coincides with an event. Giving the clear priority would drop that cause bit.

The interrupt is swept over all 256 mask values against single and mixed cause patterns. A wrong AND/OR shows up as an `irq` mismatch at a specific mask value.

// File: rtl/err_capture_unit.sv
module err_capture_unit #(
  parameter int NCAUSE = 8,
  parameter int SEL_W  = 5,
  parameter int APW    = 4,
  parameter int DPW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCAUSE-1:0] evt_valid,
  input  logic [31:0]       evt_addr,
  input  logic [APW-1:0]    evt_apar,
  input  logic [63:0]       evt_data,
  input  logic [DPW-1:0]    evt_dpar,
  output logic              irq
);
  localparam logic [2:0] IX_CAUSE = 3'd0;
  localparam logic [2:0] IX_MASK  = 3'd1;
  localparam logic [2:0] IX_ALO   = 3'd2;
  localparam logic [2:0] IX_AHI   = 3'd3;
  localparam logic [2:0] IX_DLO   = 3'd4;
  localparam logic [2:0] IX_DHI   = 3'd5;
  localparam logic [2:0] IX_DPAR  = 3'd6;
  localparam int WR_DPE = 6;
  localparam int RD_DPE = 7;
  localparam int APAR_LSB = 4;

  logic [NCAUSE-1:0] cause_q, mask_q;
  logic [SEL_W-1:0]  sel_q, first_idx;
  logic [31:0]       cap_addr_q;
  logic [APW-1:0]    cap_apar_q;
  logic [63:0]       cap_data_q;
  logic [DPW-1:0]    cap_dpar_q;
  logic              armed_q;

  wire unlock   = reg_rd && (reg_idx == IX_ALO);
  wire take     = (armed_q || unlock) && (|evt_valid);
  wire wr_cause = reg_wr && (reg_idx == IX_CAUSE);
  wire wr_mask  = reg_wr && (reg_idx == IX_MASK);
  wire data_err = (first_idx == SEL_W'(WR_DPE)) || (first_idx == SEL_W'(RD_DPE));

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:NCAUSE];

  always_comb begin
    first_idx = '0;
    for (int k = NCAUSE - 1; k >= 0; k--)
      if (evt_valid[k]) first_idx = SEL_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (wr_cause ? (cause_q & reg_wdata[NCAUSE-1:0]) : cause_q) | evt_valid;
      if (wr_mask) mask_q <= reg_wdata[NCAUSE-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q    <= 1'b1;
      sel_q      <= '0;
      cap_addr_q <= '0;
      cap_apar_q <= '0;
      cap_data_q <= '0;
      cap_dpar_q <= '0;
    end else if (take) begin
      armed_q    <= 1'b0;
      sel_q      <= first_idx;
      cap_addr_q <= evt_addr;
      cap_apar_q <= evt_apar;
      cap_data_q <= data_err ? evt_data : '0;
      cap_dpar_q <= data_err ? evt_dpar : '0;
    end else if (unlock) begin
      armed_q <= 1'b1;
    end
  end

  assign irq = |(cause_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IX_CAUSE: begin
        reg_rdata[NCAUSE-1:0] = cause_q;
        reg_rdata[31 -: SEL_W] = sel_q;
      end
      IX_MASK:  reg_rdata[NCAUSE-1:0] = mask_q;
      IX_ALO:   reg_rdata = cap_addr_q;
      IX_AHI:   reg_rdata[APAR_LSB +: APW] = cap_apar_q;
      IX_DLO:   reg_rdata = cap_data_q[31:0];
      IX_DHI:   reg_rdata = cap_data_q[63:32];
      IX_DPAR:  reg_rdata[DPW-1:0] = cap_dpar_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

module err_capture_chk #(
  parameter int NCAUSE = 8,
  parameter int SEL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_idx,
  input logic [NCAUSE-1:0] evt_valid,
  input logic [NCAUSE-1:0] cause_q,
  input logic [NCAUSE-1:0] mask_q,
  input logic              irq,
  input logic              armed_q,
  input logic              unlock,
  input logic [31:0]       cap_addr_q,
  input logic [SEL_W-1:0]  sel_q
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_valid) |=> ((cause_q & $past(evt_valid)) == $past(evt_valid))); // R2
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_idx == 3'd0) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R3
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R4
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q < SEL_W'(NCAUSE)); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !unlock) |=> ($stable(cap_addr_q) && $stable(sel_q))); // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && evt_valid == '0) |=> armed_q); // R7
  AST_UNLOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && (|evt_valid)) |=> !armed_q); // R8
endmodule

bind err_capture_unit err_capture_chk #(.NCAUSE(NCAUSE), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
  .evt_valid(evt_valid), .cause_q(cause_q), .mask_q(mask_q), .irq(irq),
  .armed_q(armed_q), .unlock(unlock), .cap_addr_q(cap_addr_q), .sel_q(sel_q)
);

// File: tb/err_capture_unit_bench.sv
module err_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_valid = '0;
  logic [31:0] evt_addr = '0;
  logic [3:0]  evt_apar = '0;
  logic [63:0] evt_data = '0;
  logic [7:0]  evt_dpar = '0;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] rv;

  err_capture_unit u_err_capture_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_addr(evt_addr), .evt_apar(evt_apar), .evt_data(evt_data),
    .evt_dpar(evt_dpar), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic [31:0] a_of(input int i); return 32'h4000_0100 + 32'(i) * 32'h0101_0011; endfunction
  function automatic [3:0]  ap_of(input int i); return 4'(i + 1); endfunction
  function automatic [63:0] d_of(input int i);
    logic [31:0] h;
    h = 32'h1111_1111 * 32'(i + 1);
    return {h, ~h};
  endfunction
  function automatic [7:0]  dp_of(input int i); return 8'h80 >> i; endfunction

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit w, input bit r, input [2:0] idx, input [31:0] wd,
                    input [7:0] ev, input [31:0] a, input [3:0] ap, input [63:0] d,
                    input [7:0] dp, output [31:0] rdv);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_idx = idx; reg_wdata = wd;
    evt_valid = ev; evt_addr = a; evt_apar = ap; evt_data = d; evt_dpar = dp;
    #1 rdv = reg_rdata;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; evt_valid = '0;
  endtask

  task automatic fire(input [7:0] ev, input int i);
    logic [31:0] t;
    op(0, 0, 3'd0, 0, ev, a_of(i), ap_of(i), d_of(i), dp_of(i), t);
  endtask
  task automatic wr(input [2:0] idx, input [31:0] wd);
    logic [31:0] t;
    op(1, 0, idx, wd, 8'h0, 0, 0, 0, 0, t);
  endtask
  task automatic rd(input [2:0] idx, output [31:0] rdv);
    op(0, 1, idx, 0, 8'h0, 0, 0, 0, 0, rdv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R9 index 7 reads zero
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), rv);
      chk("R1 reset reg", rv, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 R5 R6 sweep over every cause
    for (int i = 0; i < 8; i++) begin
      fire(8'h1 << i, i);
      rd(3'd0, rv); chk("R2 cause bit/R5 selector", rv, (32'h1 << i) | (32'(i) << 27));
      rd(3'd3, rv); chk("R5 address parity", rv, 32'(ap_of(i)) << 4);
      rd(3'd4, rv); chk("R6 data low", rv, (i >= 6) ? d_of(i)[31:0] : 32'h0);
      rd(3'd5, rv); chk("R6 data high", rv, (i >= 6) ? d_of(i)[63:32] : 32'h0);
      rd(3'd6, rv); chk("R6 data parity", rv, (i >= 6) ? 32'(dp_of(i)) : 32'h0);
      rd(3'd2, rv); chk("R5 address", rv, a_of(i));
      wr(3'd0, 32'h0);
      rd(3'd0, rv); chk("R3 clear keeps selector", rv, 32'(i) << 27);
    end

    // R7 freeze while locked, causes keep accumulating
    fire(8'h08, 3);
    fire(8'h20, 5);
    fire(8'h40, 6);
    rd(3'd0, rv); chk("R7 accumulate, selector frozen", rv, 32'h68 | (32'd3 << 27));
    rd(3'd3, rv); chk("R7 parity frozen", rv, 32'(ap_of(3)) << 4);
    rd(3'd4, rv); chk("R7 data not captured", rv, 32'h0);
    rd(3'd2, rv); chk("R7 address frozen", rv, a_of(3));
    fire(8'h20, 5);
    rd(3'd0, rv); chk("R7 rearmed selector", rv, 32'h68 | (32'd5 << 27));
    rd(3'd2, rv); chk("R7 rearmed address", rv, a_of(5));
    wr(3'd0, 32'h0);

    // R5 simultaneous events: lowest index wins
    fire(8'h44, 6);
    rd(3'd0, rv); chk("R5 priority selector", rv, 32'h44 | (32'd2 << 27));
    rd(3'd5, rv); chk("R6 no data for non-data selector", rv, 32'h0);
    rd(3'd2, rv); chk("R5 priority address", rv, a_of(6));
    wr(3'd0, 32'h0);

    // R8 event in the same cycle as the unlocking read
    fire(8'h01, 0);
    fire(8'h02, 1);
    op(0, 1, 3'd2, 0, 8'h80, a_of(7), ap_of(7), d_of(7), dp_of(7), rv);
    chk("R8 read returns old address", rv, a_of(0));
    rd(3'd0, rv); chk("R8 selector", rv, 32'h83 | (32'd7 << 27));
    rd(3'd5, rv); chk("R8 data high", rv, d_of(7)[63:32]);
    rd(3'd2, rv); chk("R8 address", rv, a_of(7));
    wr(3'd0, 32'h0);

    // R3 write-one no effect, event beats clear, R9 selector not writable
    fire(8'h10, 4);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, rv); chk("R3 write ones no effect", rv, 32'h10 | (32'd4 << 27));
    op(1, 0, 3'd0, 32'h0, 8'h02, a_of(1), 0, 0, 0, rv);
    rd(3'd0, rv); chk("R3 event wins over clear", rv, 32'h02 | (32'd4 << 27));
    rd(3'd2, rv);
    wr(3'd0, 32'h0);

    // R4 irq sweep over all masks
    for (int p = 0; p < 9; p++) begin
      logic [7:0] pat;
      pat = (p < 8) ? (8'h1 << p) : 8'hA5;
      fire(pat, p % 8);
      for (int m = 0; m < 256; m++) begin
        wr(3'd1, 32'(m));
        chk("R4 irq", {31'h0, irq}, {31'h0, |(pat & 8'(m))});
      end
      rd(3'd2, rv);
      wr(3'd0, 32'h0);
    end

    // R9 reserved bits and read-only registers
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, rv); chk("R9 mask reserved bits", rv, 32'hFF);
    fire(8'h04, 2);
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd3, rv); chk("R9 parity reg read-only", rv, 32'(ap_of(2)) << 4);
    rd(3'd7, rv); chk("R9 index 7 zero", rv, 32'h0);
    rd(3'd2, rv); chk("R9 address read-only", rv, a_of(2));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule